// File: doc/BRIEF.md
# Byte-Pair Palette RAM Port

This block is a color lookup memory that a processor or a DMA engine loads over an 8-bit register bus. Two registers sit side by side on that bus. One holds the index of the entry to load next. The other is a data port that takes bytes two at a time. The first byte of a pair is parked in a holding register. The second byte completes a 15-bit color and writes it into storage.

After each completed entry the write pointer moves on by itself. A caller therefore sets the index once and can then push an unbroken stream of bytes that fills consecutive entries. The pointer wraps from the last entry back to entry zero.

A separate registered read port lets a display pipeline fetch any entry by index while the bus side is loading.

Top module: `palette_port`

## Requirements
- R1: A bus write with `bus_sel`=0 loads the write pointer with the low IDX_W bits of `bus_wdata` and clears the pair phase, so the next data-port byte is taken as a low byte.
- R2: The first byte written to the data port (`bus_sel`=1) of a pair is only held. No storage entry changes until the second byte arrives.
- R3: The second data-port byte writes the color {second[6:0], first[7:0]} into the entry at the pointer. Bit 7 of the second byte is dropped. The color holds red in bits 4..0, green in bits 9..5 and blue in bits 14..10.
- R4: Each completed pair advances the pointer by one, so a byte stream fills consecutive entries without the index being rewritten.
- R5: After the entry at index 2^IDX_W-1 is written, the pointer wraps to 0.
- R6: Writing the index between the two bytes of a pair discards the held byte. The next data byte starts a new pair at the new index.
- R7: Synchronous active-high `rst` clears the pointer, the pair phase and the holding register. Storage contents are not reset.
- R8: `rd_color` shows the entry addressed by `rd_idx` one clock after `rd_idx` is presented.
- R9: A read of an entry in the same cycle that entry is written returns the value it held before the write.
- R10: Cycles with `bus_we`=0 change no state, whatever `bus_sel` and `bus_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe, one byte per cycle |
| bus_sel | input | 1 | Register select: 0 = index register, 1 = data port |
| bus_wdata | input | 8 | Bus write byte |
| rd_idx | input | IDX_W | Read port entry index |
| rd_color | output | 15 | Color at `rd_idx`, registered |

## Verification
The bench builds the block with IDX_W=4, which gives a 16-entry memory. With that size, one stream of 32 pairs wraps the pointer twice, and every entry can be read back and compared with arithmetic expected values. It also puts the index-register truncation within reach: an index byte of 0x1A must land on entry 10. The small depth keeps the same-cycle read/write collision, mid-pair index rewrites and resets during a pair cheap to reach, and leaves the byte-pairing logic identical to the 256-entry default.

// File: rtl/palette_port.sv
module palette_port #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic             bus_sel,
  input  logic [7:0]       bus_wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [14:0]      rd_color
);
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] ptr;
  logic             phase;
  logic [7:0]       hold;
  logic [14:0]      mem [DEPTH];

  wire idx_wr  = bus_we && !bus_sel;
  wire dat_wr  = bus_we &&  bus_sel;
  wire commit  = dat_wr && phase;
  wire [14:0] new_color = {bus_wdata[6:0], hold};

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      phase <= 1'b0;
      hold  <= '0;
    end else if (idx_wr) begin
      ptr   <= bus_wdata[IDX_W-1:0];
      phase <= 1'b0;
    end else if (dat_wr) begin
      if (phase) ptr <= ptr + 1'b1;
      else       hold <= bus_wdata;
      phase <= !phase;
    end
  end

  always_ff @(posedge clk) begin
    rd_color <= mem[rd_idx];
    if (commit) mem[ptr] <= new_color;
  end

  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
    idx_wr |=> (ptr == $past(bus_wdata[IDX_W-1:0])) && !phase); // R1
  AST_LOW_HELD: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && !phase) |=> phase && (hold == $past(bus_wdata)) && (ptr == $past(ptr))); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && phase) |=> !phase && (ptr == IDX_W'($past(ptr) + 1'b1))); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(ptr) && $stable(phase) && $stable(hold)); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (ptr == '0) && !phase && (hold == '0)); // R7
endmodule

// File: tb/palette_port_tb.sv
`timescale 1ns/1ps
module palette_port_tb;
  localparam int IDX_W = 4;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 0, rst = 1, bus_we = 0, bus_sel = 0;
  logic [7:0] bus_wdata = 0;
  logic [IDX_W-1:0] rd_idx = 0;
  logic [14:0] rd_color;
  logic [14:0] model [DEPTH];
  int checks = 0, fails = 0;

  palette_port #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .rd_idx(rd_idx), .rd_color(rd_color));

  always #4 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_sel = sel; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic pair(input logic [7:0] lo, input logic [7:0] hi);
    wr(1, lo); wr(1, hi);
  endtask

  task automatic chk(input string req, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int i, input string req, input logic [14:0] exp);
    @(negedge clk); rd_idx = IDX_W'(i);
    @(negedge clk); chk(req, rd_color, exp);
  endtask

  function automatic logic [14:0] col(input logic [7:0] lo, input logic [7:0] hi);
    return {hi[6:0], lo};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R7 pointer cleared by reset; R3 bit 7 of high byte dropped
    pair(8'h34, 8'h92);
    rd(0, "R7_R3", 15'h1234);
    // R3 field layout: blue=0x1F only
    wr(0, 8'd1); pair(8'h00, 8'h7C);
    rd(1, "R3", 15'h7C00);
    // R4 R5 R8: stream of 32 pairs from index 0 wraps twice
    wr(0, 8'd0);
    for (int i = 0; i < 2*DEPTH; i++) begin
      logic [7:0] lo, hi;
      lo = 8'((i*37 + 5) & 255); hi = 8'((i*11 + 3) & 255);
      pair(lo, hi);
      model[i % DEPTH] = col(lo, hi);
    end
    for (int i = 0; i < DEPTH; i++) rd(i, "R4_R5_R8", model[i]);
    // R5: wrap starting near the top
    wr(0, 8'(DEPTH-2));
    pair(8'hA1, 8'h01); pair(8'hA2, 8'h02); pair(8'hA3, 8'h03);
    model[DEPTH-2] = 15'h01A1; model[DEPTH-1] = 15'h02A2; model[0] = 15'h03A3;
    rd(DEPTH-1, "R5", model[DEPTH-1]);
    rd(0, "R5", model[0]);
    // R2: lone low byte changes nothing
    wr(0, 8'd3); wr(1, 8'hEE);
    rd(3, "R2", model[3]);
    // R6: index rewrite mid-pair drops held byte
    wr(0, 8'd5); pair(8'h11, 8'h22);
    model[5] = 15'h2211;
    rd(5, "R6", model[5]);
    rd(3, "R6", model[3]);
    // R1: upper index bits truncated (0x1A -> 10), next entry 11
    wr(0, 8'h1A); pair(8'h55, 8'h66); pair(8'h77, 8'h08);
    model[10] = 15'h6655; model[11] = 15'h0877;
    rd(10, "R1", model[10]);
    rd(11, "R1", model[11]);
    // R10: bus activity without strobe ignored
    wr(0, 8'd6); wr(1, 8'h99);
    @(negedge clk); bus_sel = 1; bus_wdata = 8'h44;
    @(negedge clk); bus_sel = 0; bus_wdata = 8'h0F;
    @(negedge clk);
    wr(1, 8'h33);
    model[6] = 15'h3399;
    rd(6, "R10", model[6]);
    rd(7, "R10", model[7]);
    // R9: read during commit returns old value
    wr(0, 8'd7); wr(1, 8'hC4);
    @(negedge clk); rd_idx = 7; bus_we = 1; bus_sel = 1; bus_wdata = 8'h1B;
    @(negedge clk); bus_we = 0;
    chk("R9", rd_color, model[7]);
    model[7] = 15'h1BC4;
    @(negedge clk); chk("R9", rd_color, model[7]);
    // R7: reset mid-pair clears phase and pointer
    wr(0, 8'd9); wr(1, 8'hFF);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    pair(8'h5A, 8'h25);
    rd(0, "R7", 15'h255A);
    rd(9, "R7", model[9]);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule